// File: doc/BRIEF.md
# Two-Channel Host-to-Slave Mailbox

This block connects an external parallel host bus to an internal slave processor through two independent byte-wide mailbox channels. Each channel holds three registers: an inbound byte that the host writes and the slave reads, an outbound byte that the slave writes and the host reads, and an 8-bit status word. The status word carries two fullness flags, a copy of the host address line taken at the last host write, and five spare flags that the slave may use freely.

The host side is asynchronous to the slave clock. Read and write strobes pass through a synchroniser, and their rising edges are detected, so each host access acts on the registers once. The host selects a channel with one select line per channel. The address line A0 picks status (high) or the outbound byte (low) on reads. On writes, A0 is recorded so that the slave can tell command bytes from data bytes. The slave side is a plain synchronous register port. Every channel has one data address and one status address.

Top module: `host_mailbox`

## Requirements
- R1: A synchronous active-high reset clears every status flag, the inbound byte and the outbound byte to 0.
- R2: Status bit 0 (outbound full) becomes 1 on a slave write to a channel's data address. It becomes 0 on a host read with A0 low.
- R3: Status bit 1 (inbound full) becomes 1 on a host write. It becomes 0 on a slave read of the channel's data address. A slave read of the status address leaves it unchanged.
- R4: Status bit 3 holds the A0 level of the most recent host write, and it keeps that value after the slave reads the inbound byte.
- R5: A host write stores `host_din` in the inbound byte. A slave read of the data address returns that byte.
- R6: With one channel selected, `host_dout` shows the status word when A0 is 1 and the outbound byte when A0 is 0. With no channel selected, it shows 0.
- R7: A slave write to the status address updates only bits 7, 6, 5, 4 and 2. Bits 0, 1 and 3 keep their values.
- R8: A host strobe held high for many cycles acts only once. A flag that the slave clears during a held write strobe stays clear. A flag that the slave sets during a held read strobe stays set.
- R9: When a flag's set event and clear event fall in the same clock cycle, the flag ends at 1.
- R10: A host write to a full inbound byte replaces the data and leaves bit 1 at 1. A host read of an empty outbound byte returns the last value written and changes no flag.
- R11: Slave address `{channel, s}` selects the data register (s=0) or the status register (s=1) of that channel. Accesses to one channel do not change the other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slave clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | NCH | Host channel select, one bit per channel |
| host_rd | input | 1 | Host read strobe, active high, asynchronous |
| host_wr | input | 1 | Host write strobe, active high, asynchronous |
| host_a0 | input | 1 | Host address line: 1 selects status, 0 selects data |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| slv_addr | input | $clog2(NCH)+1 | Slave address: channel in the upper bits, status select in bit 0 |
| slv_rd | input | 1 | Slave read enable, one cycle per access |
| slv_wr | input | 1 | Slave write enable, one cycle per access |
| slv_wdata | input | 8 | Slave write data |
| slv_rdata | output | 8 | Slave read data |

## Verification
The assertions assume that `host_sel`, `host_a0` and `host_din` are stable from before a strobe rises until after it falls. They also assume that at most one select bit is high and that read and write strobes are never high together. The stimulus sets up select, address and data one cycle before raising a strobe and releases them only after the strobe has been low for several cycles. Slave enables are driven as single-cycle pulses between clock edges. The same-cycle tests place a slave pulse exactly on the cycle in which the synchronised host edge takes effect.

// File: rtl/hmb_pkg.sv
package hmb_pkg;

    localparam int BYTE_W = 8;

    // Status word layout; bit positions are read by the host
    typedef struct packed {
        logic [3:0] usr_hi;    // bits 7..4 slave flags
        logic       cmd_flag;  // bit 3 A0 of last host write
        logic       usr_lo;    // bit 2 slave flag
        logic       in_full;   // bit 1
        logic       out_full;  // bit 0
    } hmb_stat_t;

    localparam logic [BYTE_W-1:0] USR_MASK = 8'hF4;

    // One slave-side access already decoded for a single channel
    typedef struct packed {
        logic              rd_data;
        logic              wr_data;
        logic              wr_stat;
        logic [BYTE_W-1:0] wdata;
    } slv_req_t;

    function automatic hmb_stat_t merge_user(hmb_stat_t cur, logic [BYTE_W-1:0] wd);
        return hmb_stat_t'((cur & ~USR_MASK) | (wd & USR_MASK));
    endfunction

    // Set dominates clear
    function automatic logic next_flag(logic cur, logic set, logic clr);
        if (set)      return 1'b1;
        else if (clr) return 1'b0;
        return cur;
    endfunction

endpackage

// File: rtl/hmb_edge_sync.sv
module hmb_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], async_in};
    end

    assign rise_pulse = chain[STAGES-1] & ~chain[STAGES];

    // R8: a detected edge never lasts two cycles
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/hmb_channel.sv
module hmb_channel
    import hmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic              h_a0,
    input  logic [BYTE_W-1:0] h_data,
    input  slv_req_t          sreq,
    output logic [BYTE_W-1:0] ibuf,
    output logic [BYTE_W-1:0] obuf,
    output hmb_stat_t         stat
);
    hmb_stat_t stat_nx;

    always_comb begin
        stat_nx = stat;
        if (sreq.wr_stat) stat_nx = merge_user(stat, sreq.wdata);
        stat_nx.in_full  = next_flag(stat.in_full,  h_wr, sreq.rd_data);
        stat_nx.out_full = next_flag(stat.out_full, sreq.wr_data, h_rd);
        if (h_wr) stat_nx.cmd_flag = h_a0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            ibuf <= '0;
            obuf <= '0;
        end else begin
            stat <= stat_nx;
            if (h_wr)         ibuf <= h_data;
            if (sreq.wr_data) obuf <= sreq.wdata;
        end
    end

    a_r2_out_set: assert property (@(posedge clk) disable iff (rst)
        sreq.wr_data |=> stat.out_full && obuf == $past(sreq.wdata));
    a_r2_out_clr: assert property (@(posedge clk) disable iff (rst)
        h_rd && !sreq.wr_data |=> !stat.out_full);
    a_r3_in_set: assert property (@(posedge clk) disable iff (rst)
        h_wr |=> stat.in_full);
    a_r3_in_clr: assert property (@(posedge clk) disable iff (rst)
        sreq.rd_data && !h_wr |=> !stat.in_full);
    a_r4_cmd_capture: assert property (@(posedge clk) disable iff (rst)
        h_wr |=> stat.cmd_flag == $past(h_a0));
    a_r5_data_capture: assert property (@(posedge clk) disable iff (rst)
        h_wr |=> ibuf == $past(h_data));
    a_r7_hw_bits_kept: assert property (@(posedge clk) disable iff (rst)
        sreq.wr_stat && !h_wr && !h_rd && !sreq.rd_data && !sreq.wr_data
        |=> $stable(stat.in_full) && $stable(stat.out_full) && $stable(stat.cmd_flag));
    a_r9_set_wins_in: assert property (@(posedge clk) disable iff (rst)
        h_wr && sreq.rd_data |=> stat.in_full);
    a_r9_set_wins_out: assert property (@(posedge clk) disable iff (rst)
        sreq.wr_data && h_rd |=> stat.out_full);

endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
    import hmb_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCH-1:0]         host_sel,
    input  logic                   host_rd,
    input  logic                   host_wr,
    input  logic                   host_a0,
    input  logic [BYTE_W-1:0]      host_din,
    output logic [BYTE_W-1:0]      host_dout,
    input  logic [$clog2(NCH):0]   slv_addr,
    input  logic                   slv_rd,
    input  logic                   slv_wr,
    input  logic [BYTE_W-1:0]      slv_wdata,
    output logic [BYTE_W-1:0]      slv_rdata
);
    localparam int CH_W = $clog2(NCH);

    logic wr_pulse, rd_pulse;
    logic [CH_W-1:0] slv_ch;

    hmb_stat_t         ch_stat [NCH];
    logic [BYTE_W-1:0] ch_ibuf [NCH];
    logic [BYTE_W-1:0] ch_obuf [NCH];

    assign slv_ch = slv_addr[CH_W:1];

    hmb_edge_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst(rst), .async_in(host_wr), .rise_pulse(wr_pulse));
    hmb_edge_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst(rst), .async_in(host_rd), .rise_pulse(rd_pulse));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        slv_req_t req;
        logic     hit;
        assign hit         = slv_ch == CH_W'(c);
        assign req.rd_data = slv_rd & hit & ~slv_addr[0];
        assign req.wr_data = slv_wr & hit & ~slv_addr[0];
        assign req.wr_stat = slv_wr & hit &  slv_addr[0];
        assign req.wdata   = slv_wdata;

        hmb_channel u_ch (
            .clk   (clk),
            .rst   (rst),
            .h_wr  (wr_pulse & host_sel[c]),
            .h_rd  (rd_pulse & host_sel[c] & ~host_a0),
            .h_a0  (host_a0),
            .h_data(host_din),
            .sreq  (req),
            .ibuf  (ch_ibuf[c]),
            .obuf  (ch_obuf[c]),
            .stat  (ch_stat[c])
        );
    end

    // Lowest selected channel drives the host bus
    always_comb begin
        host_dout = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (host_sel[c]) host_dout = host_a0 ? BYTE_W'(ch_stat[c]) : ch_obuf[c];
        end
    end

    always_comb begin
        slv_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (slv_ch == CH_W'(c))
                slv_rdata = slv_addr[0] ? BYTE_W'(ch_stat[c]) : ch_ibuf[c];
        end
    end

    // R6: nothing selected means a quiet host bus
    a_r6_idle_bus: assert property (@(posedge clk) disable iff (rst)
        host_sel == '0 |-> host_dout == '0);

endmodule

// File: tb/host_mailbox_tb.sv
module host_mailbox_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] host_sel = '0;
    logic       host_rd = 1'b0, host_wr = 1'b0, host_a0 = 1'b0;
    logic [7:0] host_din = '0;
    logic [7:0] host_dout;
    logic [1:0] slv_addr = '0;
    logic       slv_rd = 1'b0, slv_wr = 1'b0;
    logic [7:0] slv_wdata = '0;
    logic [7:0] slv_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    host_mailbox u_dut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_rd(host_rd),
        .host_wr(host_wr), .host_a0(host_a0), .host_din(host_din),
        .host_dout(host_dout), .slv_addr(slv_addr), .slv_rd(slv_rd),
        .slv_wr(slv_wr), .slv_wdata(slv_wdata), .slv_rdata(slv_rdata));

    // op: 1 host wr, 2 host rd, 3 slave wr data, 4 slave wr status,
    //     5 slave rd data, 6 slave rd status
    // fields: {op, req, ch, a0, data, expected}
    localparam int NV = 23;
    localparam logic [31:0] TBL [NV] = '{
        32'h3_2_0_0_A5_00,  // R2 slave loads outbound
        32'h2_2_0_1_00_01,  // R2 out_full visible
        32'h2_6_0_0_00_A5,  // R6 A0 low reads outbound
        32'h2_2_0_1_00_00,  // R2 cleared by host read
        32'h1_3_0_0_3C_00,  // R3 host write
        32'h6_3_0_0_00_02,  // R3 in_full
        32'h5_5_0_0_00_3C,  // R5 slave reads byte
        32'h6_3_0_0_00_00,  // R3 cleared
        32'h1_4_0_1_81_00,  // R4 command write
        32'h2_4_0_1_00_0A,  // R4 bit 3 set
        32'h4_7_0_0_FF_00,  // R7 write all ones
        32'h6_7_0_0_00_FE,  // R7 hw bits kept
        32'h4_7_0_0_00_00,  // R7 write zeros
        32'h2_7_0_1_00_0A,  // R7 hw bits still kept
        32'h3_B_1_0_5A_00,  // R11 channel 1 outbound
        32'h2_B_1_1_00_01,  // R11 channel 1 status
        32'h2_B_0_1_00_0A,  // R11 channel 0 untouched
        32'h5_5_0_0_00_81,  // R5 read command byte
        32'h6_4_0_0_00_08,  // R4 flag persists
        32'h1_B_1_0_77_00,  // R11 channel 1 host write
        32'h5_B_1_0_00_77,  // R11 address 2 is ch1 data
        32'h2_A_0_0_00_A5,  // R10 empty read keeps value
        32'h2_A_0_1_00_08   // R10 no flag change
    };

    function automatic string rname(int n);
        case (n)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(int ch, logic a0, logic [7:0] d);
        host_sel = 2'(1 << ch); host_a0 = a0; host_din = d;
        wait_n(1);
        host_wr = 1'b1; wait_n(4);
        host_wr = 1'b0; wait_n(4);
        host_sel = '0;
    endtask

    task automatic host_read(int ch, logic a0, output logic [7:0] d);
        host_sel = 2'(1 << ch); host_a0 = a0;
        wait_n(1);
        host_rd = 1'b1; wait_n(4);
        d = host_dout;
        host_rd = 1'b0; wait_n(4);
        host_sel = '0;
    endtask

    task automatic slave_write(int ch, logic st, logic [7:0] d);
        slv_addr = {1'(ch), st}; slv_wdata = d; slv_wr = 1'b1;
        wait_n(1);
        slv_wr = 1'b0;
    endtask

    task automatic slave_read(int ch, logic st, output logic [7:0] d);
        slv_addr = {1'(ch), st}; slv_rd = 1'b1;
        #1 d = slv_rdata;
        wait_n(1);
        slv_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);

        // R1: reset state
        check("R1", host_dout, 8'h00);
        slave_read(0, 1'b1, rv); check("R1", rv, 8'h00);
        slave_read(1, 1'b1, rv); check("R1", rv, 8'h00);
        slave_read(0, 1'b0, rv); check("R1", rv, 8'h00);
        host_read(1, 1'b1, rv);  check("R1", rv, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [3:0] op, rq;
            int         ch;
            logic       a0;
            logic [7:0] dv, ev;
            op = TBL[i][31:28]; rq = TBL[i][27:24]; ch = int'(TBL[i][23:20]);
            a0 = TBL[i][16];    dv = TBL[i][15:8];  ev = TBL[i][7:0];
            case (op)
                4'd1: host_write(ch, a0, dv);
                4'd2: begin host_read(ch, a0, rv);     check(rname(int'(rq)), rv, ev); end
                4'd3: slave_write(ch, 1'b0, dv);
                4'd4: slave_write(ch, 1'b1, dv);
                4'd5: begin slave_read(ch, 1'b0, rv);  check(rname(int'(rq)), rv, ev); end
                4'd6: begin slave_read(ch, 1'b1, rv);  check(rname(int'(rq)), rv, ev); end
                default: ;
            endcase
            wait_n(1);
        end

        // R10: overwrite while full
        host_write(1, 1'b0, 8'h11);
        host_write(1, 1'b0, 8'h22);
        slave_read(1, 1'b1, rv); check("R10", rv, 8'h03);
        slave_read(1, 1'b0, rv); check("R10", rv, 8'h22);
        slave_read(1, 1'b1, rv); check("R10", rv, 8'h01);

        // R8: held write strobe acts once
        host_sel = 2'b01; host_a0 = 1'b0; host_din = 8'h44;
        wait_n(1);
        host_wr = 1'b1; wait_n(6);
        slave_read(0, 1'b0, rv); check("R8", rv, 8'h44);
        wait_n(8);
        slave_read(0, 1'b1, rv); check("R8", rv, 8'h00);
        host_wr = 1'b0; wait_n(4);
        // R8: held read strobe acts once
        host_rd = 1'b1; wait_n(6);
        slave_write(0, 1'b0, 8'h99);
        wait_n(6);
        slave_read(0, 1'b1, rv); check("R8", rv, 8'h01);
        host_rd = 1'b0; wait_n(4);
        host_sel = '0;
        host_read(0, 1'b0, rv);  check("R2", rv, 8'h99);
        slave_read(0, 1'b1, rv); check("R2", rv, 8'h00);

        // R9: host write and slave read land in the same cycle
        host_sel = 2'b01; host_a0 = 1'b1; host_din = 8'h12;
        wait_n(1);
        host_wr = 1'b1;
        wait_n(2);
        slv_addr = 2'b00; slv_rd = 1'b1;
        #1 rv = slv_rdata;
        wait_n(1);
        slv_rd = 1'b0;
        check("R9", rv, 8'h44);
        wait_n(2);
        host_wr = 1'b0; wait_n(4);
        slave_read(0, 1'b1, rv); check("R9", rv, 8'h0A);
        // R9: slave write and host read land in the same cycle
        host_a0 = 1'b0;
        wait_n(1);
        host_rd = 1'b1;
        wait_n(2);
        slv_addr = 2'b00; slv_wdata = 8'h66; slv_wr = 1'b1;
        wait_n(1);
        slv_wr = 1'b0;
        wait_n(2);
        host_rd = 1'b0; wait_n(4);
        host_sel = '0;
        slave_read(0, 1'b1, rv); check("R9", rv, 8'h0B);
        host_read(0, 1'b0, rv);  check("R9", rv, 8'h66);

        // R1: reset in mid-run
        slave_write(0, 1'b1, 8'hF4);
        rst = 1'b1; wait_n(2);
        rst = 1'b0; wait_n(1);
        slave_read(0, 1'b1, rv); check("R1", rv, 8'h00);
        slave_read(1, 1'b1, rv); check("R1", rv, 8'h00);
        slave_read(1, 1'b0, rv); check("R1", rv, 8'h00);
        host_read(1, 1'b0, rv);  check("R1", rv, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule